// File: doc/BRIEF.md
# Timer I/O Port Hub with Oscillator Tick Divider

This block sits between a byte-wide register bus and three external timer channels. A two-bit offset picks one of four timer ports. Offsets 0 to 2 reach the data registers of channels 0 to 2. Offset 3 is a command port that can only be written. The top two bits of a command byte decide which channel receives it. A separate speaker register holds the gate enable for channel 2, and a read of it also shows the present output of channel 2.

The block also makes the clock-enable tick that drives the channels. It turns a fast system clock into the nominal 1193182 Hz timer rate. A phase accumulator adds the oscillator rate on every system cycle. When the sum reaches the system rate, the block emits one tick and keeps the overshoot as the starting phase for the next period, so no fractional cycles are lost.

An output-change event from channel 0 becomes a request on interrupt line 0. Every access must be one byte wide. A wider or empty access, or a read of the command port, changes nothing and raises a one-cycle error pulse.

Top module: `tmr_io_hub`

## Requirements
- R1: A valid write (size 1, bus_spk low) to offset 0, 1 or 2 raises only bit `offset` of `ch_data_wr` in the same cycle, and `ch_wdata` carries the written byte.
- R2: A valid read of offset 0, 1 or 2 raises only bit `offset` of `ch_data_rd` in the same cycle. In the next cycle `bus_rvalid` is high and `bus_rdata` equals byte `offset` of `ch_rdata` (bits 8*offset+7 down to 8*offset). `bus_rdata` keeps that value until the next valid read.
- R3: A valid write to offset 3 raises `ch_cmd_wr[n]` in the same cycle, where n is written-byte bits 7:6. The value 3 raises no strobe and no error.
- R4: A read of offset 3 raises no strobe. In the next cycle `bus_err` is high for one cycle, `bus_rvalid` is low and `bus_rdata` is unchanged.
- R5: Any access whose `bus_size` is not 1 raises no strobe and changes neither the speaker register nor `bus_rdata`. In the next cycle `bus_err` is high for one cycle.
- R6: A valid speaker write (bus_spk high) stores the byte with bit 5 cleared. From the next cycle, `ch_gate2` equals stored bit 0.
- R7: A valid speaker read returns the stored byte one cycle later. Bit 5 of the returned byte is `ch_out2` when stored bit 0 is 1, and 0 otherwise.
- R8: Counting k from the first clock edge after reset is released, `tmr_tick` after edge k equals floor(k*OSC_HZ/SYS_HZ) - floor((k-1)*OSC_HZ/SYS_HZ). This requires OSC_HZ <= SYS_HZ.
- R9: `irq0` is high in the cycle after `ch0_evt` is high, and low in the cycle after `ch0_evt` is low.
- R10: During and right after reset, `bus_rdata` is 0, and `bus_rvalid`, `bus_err`, `ch_gate2`, `tmr_tick` and `irq0` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_spk | input | 1 | 1 = speaker register, 0 = timer ports |
| bus_off | input | 2 | Timer port offset (0..2 data, 3 command) |
| bus_size | input | 3 | Access size in bytes; only 1 is valid |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, held until the next valid read |
| bus_rvalid | output | 1 | Read data returned this cycle |
| bus_err | output | 1 | Invalid access pulse |
| ch_wdata | output | 8 | Byte forwarded to the channels |
| ch_data_wr | output | 3 | Per-channel data write strobe |
| ch_data_rd | output | 3 | Per-channel data read strobe |
| ch_cmd_wr | output | 3 | Per-channel command write strobe |
| ch_rdata | input | 24 | Read bytes from channels, byte n from channel n |
| ch_out2 | input | 1 | Channel 2 output level |
| ch_gate2 | output | 1 | Channel 2 gate enable |
| ch0_evt | input | 1 | Channel 0 output-change event |
| tmr_tick | output | 1 | Oscillator-rate clock enable for the channels |
| irq0 | output | 1 | Interrupt line 0 request |

## Verification
The channel strobes and `ch_wdata` are combinational. The bench reads them just after it drives a request, before the clock edge. Read data, `bus_rvalid`, `bus_err`, `ch_gate2` and `irq0` each pass through one register, so the bench samples them at the falling edge after the edge that captured the request. The tick is due after every edge, and the bench compares it cycle by cycle with the floor-difference formula, using a small 3-in-7 ratio.

// File: rtl/tmr_io_hub.sv
module tmr_io_hub #(
  parameter int unsigned SYS_HZ = 100_000_000,
  parameter int unsigned OSC_HZ = 1_193_182
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic        bus_spk,
  input  logic [1:0]  bus_off,
  input  logic [2:0]  bus_size,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_rvalid,
  output logic        bus_err,
  output logic [7:0]  ch_wdata,
  output logic [2:0]  ch_data_wr,
  output logic [2:0]  ch_data_rd,
  output logic [2:0]  ch_cmd_wr,
  input  logic [23:0] ch_rdata,
  input  logic        ch_out2,
  output logic        ch_gate2,
  input  logic        ch0_evt,
  output logic        tmr_tick,
  output logic        irq0
);
  localparam int PW = $clog2(SYS_HZ + OSC_HZ) + 1;
  localparam logic [PW-1:0] SYS_W = PW'(SYS_HZ);
  localparam logic [PW-1:0] OSC_W = PW'(OSC_HZ);

  logic [7:0]    spkr;
  logic [7:0]    rd_byte;
  logic [PW-1:0] phase;
  logic [PW-1:0] phase_sum;

  wire ok       = bus_req && (bus_size == 3'd1);
  wire on_port  = ok && !bus_spk;
  wire is_cmd   = bus_off == 2'd3;
  wire dat      = on_port && !is_cmd;
  wire cmd      = on_port && is_cmd && bus_wr;
  wire bad      = (bus_req && bus_size != 3'd1) || (on_port && is_cmd && !bus_wr);
  wire rd_go    = ok && !bus_wr && (bus_spk || !is_cmd);
  wire spk_wr   = ok && bus_spk && bus_wr;

  assign ch_wdata = bus_wdata;
  assign ch_gate2 = spkr[0];

  for (genvar i = 0; i < 3; i++) begin : g_ch
    assign ch_data_wr[i] = dat && bus_wr && (bus_off == 2'(i));
    assign ch_data_rd[i] = dat && !bus_wr && (bus_off == 2'(i));
    assign ch_cmd_wr[i]  = cmd && (bus_wdata[7:6] == 2'(i));
  end

  always_comb begin
    if (bus_spk) rd_byte = spkr | {2'b00, spkr[0] & ch_out2, 5'b00000};
    else begin
      case (bus_off)
        2'd0:    rd_byte = ch_rdata[7:0];
        2'd1:    rd_byte = ch_rdata[15:8];
        default: rd_byte = ch_rdata[23:16];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spkr       <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      irq0       <= 1'b0;
    end else begin
      if (spk_wr) spkr <= bus_wdata & 8'hDF;
      if (rd_go) bus_rdata <= rd_byte;
      bus_rvalid <= rd_go;
      bus_err    <= bad;
      irq0       <= ch0_evt;
    end
  end

  assign phase_sum = phase + OSC_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      tmr_tick <= 1'b0;
    end else if (phase_sum >= SYS_W) begin
      phase    <= phase_sum - SYS_W;
      tmr_tick <= 1'b1;
    end else begin
      phase    <= phase_sum;
      tmr_tick <= 1'b0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_data_wr, ch_data_rd, ch_cmd_wr})); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == $past(bus_rdata)); // R2
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !bus_rvalid); // R4
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size != 3'd1) |=> bus_err && $stable(ch_gate2)); // R5
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_evt |=> irq0); // R9
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase < SYS_W); // R8
endmodule

// File: tb/tmr_io_hub_bench.sv
module tmr_io_hub_bench;
  localparam int S = 7;
  localparam int O = 3;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0, bus_spk = 0;
  logic [1:0] bus_off = 0;
  logic [2:0] bus_size = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, ch_wdata;
  logic bus_rvalid, bus_err, ch_gate2, tmr_tick, irq0;
  logic [2:0] ch_data_wr, ch_data_rd, ch_cmd_wr;
  logic [23:0] ch_rdata = 0;
  logic ch_out2 = 0, ch0_evt = 0;

  int checks = 0, fails = 0, k = 0;
  bit done = 0;
  logic [2:0] s_dwr, s_drd, s_cmd;
  logic [7:0] s_wd, s_rd;
  logic s_err, s_rv;

  tmr_io_hub #(.SYS_HZ(S), .OSC_HZ(O)) u_tmr_io_hub (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) k <= k + 1;

  always @(negedge clk) begin
    if (rst_n && k > 0 && k <= 300)
      chk("R8 tick", int'(tmr_tick), (k * O) / S - ((k - 1) * O) / S);
  end

  task automatic acc(input bit spk, input bit wr, input int off, input int size, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_spk = spk; bus_wr = wr; bus_off = off[1:0];
    bus_size = size[2:0]; bus_wdata = d;
    #1;
    s_dwr = ch_data_wr; s_drd = ch_data_rd; s_cmd = ch_cmd_wr; s_wd = ch_wdata;
    @(negedge clk);
    s_err = bus_err; s_rv = bus_rvalid; s_rd = bus_rdata;
    bus_req = 0;
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] exp_rd;
    logic [7:0] spk_vals [6];
    logic [7:0] stored;
    int it;
    spk_vals = '{8'hFF, 8'h21, 8'h00, 8'hE0, 8'h5A, 8'h01};
    repeat (3) @(negedge clk);
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 rvalid", bus_rvalid, 0);
    chk("R10 err", bus_err, 0);
    chk("R10 gate", ch_gate2, 0);
    chk("R10 tick", tmr_tick, 0);
    chk("R10 irq", irq0, 0);
    rst_n = 1;

    exp_rd = 0;
    it = 0;
    for (int off = 0; off < 4; off++)
      for (int wr = 0; wr < 2; wr++)
        for (int size = 0; size < 5; size++) begin
          logic [7:0] d;
          bit valid;
          logic [2:0] e_dwr, e_drd, e_cmd;
          it++;
          d = 8'(it * 37 + off * 64);
          ch_rdata = {8'(8'h90 + it), 8'(8'h50 + it), 8'(8'h10 + it)};
          valid = (size == 1);
          e_dwr = (valid && wr == 1 && off < 3) ? 3'(1 << off) : 3'd0;
          e_drd = (valid && wr == 0 && off < 3) ? 3'(1 << off) : 3'd0;
          e_cmd = (valid && wr == 1 && off == 3 && d[7:6] != 2'd3) ? 3'(1 << d[7:6]) : 3'd0;
          acc(0, wr[0], off, size, d);
          chk("R1 data write strobe", s_dwr, e_dwr);
          if (e_dwr != 0) chk("R1 wdata", s_wd, d);
          chk("R2 data read strobe", s_drd, e_drd);
          chk("R3 command strobe", s_cmd, e_cmd);
          chk("R4 R5 error", s_err, int'(!valid || (wr == 0 && off == 3)));
          chk("R2 rvalid", s_rv, int'(e_drd != 0));
          if (e_drd != 0) exp_rd = ch_rdata[off*8 +: 8];
          chk("R2 R4 R5 rdata", s_rd, exp_rd);
        end

    for (int n = 0; n < 4; n++) begin
      acc(0, 1, 3, 1, {2'(n), 6'h15});
      chk("R3 select sweep", s_cmd, n == 3 ? 0 : (1 << n));
      chk("R3 no error", s_err, 0);
    end

    for (int v = 0; v < 6; v++) begin
      stored = spk_vals[v] & 8'hDF;
      acc(1, 1, 0, 1, spk_vals[v]);
      chk("R6 gate", ch_gate2, stored[0]);
      for (int o = 0; o < 2; o++) begin
        ch_out2 = o[0];
        acc(1, 0, 0, 1, 8'h00);
        chk("R7 speaker read", s_rd, stored | ((stored[0] & o[0]) ? 8'h20 : 8'h00));
        chk("R7 rvalid", s_rv, 1);
      end
    end

    acc(1, 1, 0, 2, 8'hFE);
    chk("R5 speaker bad size err", s_err, 1);
    chk("R5 speaker gate kept", ch_gate2, 1);
    ch_out2 = 0;
    acc(1, 0, 0, 1, 8'h00);
    chk("R5 speaker kept", s_rd, 8'h01);
    acc(1, 0, 0, 0, 8'h00);
    chk("R5 read size 0 err", s_err, 1);
    chk("R5 read size 0 rdata kept", s_rd, 8'h01);
    @(negedge clk);
    chk("R4 error is one cycle", bus_err, 0);

    @(negedge clk); ch0_evt = 1;
    @(negedge clk); chk("R9 irq raised", irq0, 1); ch0_evt = 0;
    @(negedge clk); chk("R9 irq dropped", irq0, 0);

    while (k <= 305) @(negedge clk);
    finish_run();
  end
endmodule